// File: doc/BRIEF.md
# Receive Read Pointer with Atomic Byte Update

This block holds the 13-bit pointer that marks how far a host has consumed a circular receive buffer. The host reaches it over an 8-bit register bus, so the pointer has to be written as two separate bytes. A half-written pointer must never become visible to the receive logic. The block prevents this by keeping the low byte in a hidden staging register. The live pointer only changes when the host writes the high byte, and then it takes the new high bits and the staged low byte together in one clock edge.

From the live pointer, the committed hardware write pointer and the buffer's start and end bounds, the block also computes how much buffer space is free. One byte is always kept empty so that a full buffer can be told apart from an empty one, and the free-space value reflects that lost byte. The receive logic reads the full pointer directly, and the host reads the pointer back one byte at a time.

Top module: `rxptr_atomic`

## Requirements
- R1: A write with `wr_sel` = 0 (low byte) stores `wr_data` in the staging register only. `rd_ptr_o` and both read-back bytes keep their previous value.
- R2: A write with `wr_sel` = 1 (high byte) sets `rd_ptr_o` to {`wr_data[4:0]`, staged low byte}. The new value appears after that same clock edge.
- R3: With `rd_sel` = 0, `rd_data` shows `rd_ptr_o[7:0]`. With `rd_sel` = 1, it shows {3'b000, `rd_ptr_o[12:8]`}. The read path is combinational, works in either order, and never shows the staged low byte.
- R4: Bits 7 to 5 of a high-byte write are ignored, and they always read back as zero.
- R5: A synchronous active-high reset clears both the live pointer and the staging register to zero.
- R6: When the write pointer is greater than the read pointer, `free_o` = (end − start) − (write − read).
- R7: When the write pointer equals the read pointer, `free_o` = end − start.
- R8: When the write pointer is less than the read pointer, `free_o` = read − write − 1.
- R9: The staging register keeps the last low byte written. If several low-byte writes come before a commit, the last one is used. Committing a high byte does not clear the staging register, so a later high-byte write reuses the same low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 1 | Byte select for writes: 0 = low, 1 = high |
| wr_data | input | 8 | Write data byte |
| rd_sel | input | 1 | Byte select for read-back: 0 = low, 1 = high |
| rd_data | output | 8 | Read-back byte of the live pointer |
| hw_wr_ptr_i | input | 13 | Committed hardware write pointer |
| buf_start_i | input | 13 | Start bound of the receive buffer |
| buf_end_i | input | 13 | End bound of the receive buffer |
| rd_ptr_o | output | 13 | Live read pointer |
| free_o | output | 13 | Free receive-buffer space in bytes |

## Verification
The byte-update path is driven with four patterns, and each one tells a different fault apart:
- A lone low-byte write shows whether the staged byte leaks into the live pointer or into the read port.
- A high-byte write after it shows whether the commit picks up the staged byte.
- A high byte with its upper bits set shows whether those bits are ignored.
- Repeated low writes followed by two commits show that the last staged byte is the one used, and that it survives a commit.

A reset taken while a low byte is still staged shows whether the staging register is cleared as well as the live pointer. The free-space output is tried with the write pointer ahead of, equal to, and behind the read pointer, including the cases one byte ahead and one byte behind. These separate the three formulas and expose an off-by-one on the lost byte.

// File: rtl/rxptr_pkg.sv
package rxptr_pkg;

    localparam int PTR_W  = 13;
    localparam int BYTE_W = 8;

    typedef enum logic {
        SEL_LO = 1'b0,
        SEL_HI = 1'b1
    } byte_sel_e;

    typedef enum logic [1:0] {
        WR_AHEAD  = 2'd0,
        WR_EQUAL  = 2'd1,
        WR_BEHIND = 2'd2
    } ptr_order_e;

    function automatic ptr_order_e order_of(input logic [PTR_W-1:0] wr,
                                            input logic [PTR_W-1:0] rd);
        if (wr > rd)       return WR_AHEAD;
        else if (wr == rd) return WR_EQUAL;
        else               return WR_BEHIND;
    endfunction

endpackage

// File: rtl/rxptr_stage_reg.sv
module rxptr_stage_reg
    import rxptr_pkg::*;
#(
    parameter int PTR_W  = rxptr_pkg::PTR_W,
    parameter int BYTE_W = rxptr_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  byte_sel_e         wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [PTR_W-1:0]  ptr_q
);
    localparam int HI_W = PTR_W - BYTE_W;

    logic [BYTE_W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            ptr_q   <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_LO) stage_q <= wr_data;
            else                  ptr_q   <= {wr_data[HI_W-1:0], stage_q};
        end
    end

    // R1
    lo_write_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_LO) |=> $stable(ptr_q));

    // R2
    hi_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_HI) |=>
            (ptr_q == {$past(wr_data[HI_W-1:0]), $past(stage_q)}));

    // R9
    stage_kept_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel == SEL_LO) |=> $stable(stage_q));

    // R5
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (ptr_q == '0 && stage_q == '0));

endmodule

// File: rtl/rxptr_read_mux.sv
module rxptr_read_mux
    import rxptr_pkg::*;
#(
    parameter int PTR_W  = rxptr_pkg::PTR_W,
    parameter int BYTE_W = rxptr_pkg::BYTE_W
) (
    input  logic [PTR_W-1:0]  ptr,
    input  byte_sel_e         rd_sel,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int HI_W = PTR_W - BYTE_W;

    logic [BYTE_W-1:0] hi_byte;

    generate
        if (HI_W < BYTE_W) begin : g_pad
            assign hi_byte = {{(BYTE_W-HI_W){1'b0}}, ptr[PTR_W-1:BYTE_W]};
        end else begin : g_full
            assign hi_byte = ptr[PTR_W-1:BYTE_W];
        end
    endgenerate

    always_comb begin
        rd_data = (rd_sel == SEL_HI) ? hi_byte : ptr[BYTE_W-1:0];
    end

endmodule

// File: rtl/rxptr_free_calc.sv
module rxptr_free_calc
    import rxptr_pkg::*;
#(
    parameter int PTR_W = rxptr_pkg::PTR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [PTR_W-1:0] base,
    input  logic [PTR_W-1:0] lim,
    output logic [PTR_W-1:0] free_space
);
    ptr_order_e       order;
    logic [PTR_W-1:0] span;
    logic [PTR_W-1:0] used;

    always_comb begin
        order = order_of(wr_ptr, rd_ptr);
        span  = lim - base;
        used  = wr_ptr - rd_ptr;
        unique case (order)
            WR_AHEAD: free_space = span - used;
            WR_EQUAL: free_space = span;
            default:  free_space = rd_ptr - wr_ptr - 1'b1;
        endcase
    end

    // R8
    behind_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ptr < rd_ptr) |-> (PTR_W'(free_space + wr_ptr + 1'b1) == rd_ptr));

    // R6
    ahead_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ptr > rd_ptr) |-> (PTR_W'(free_space + wr_ptr - rd_ptr) == PTR_W'(lim - base)));

    // R7
    equal_span_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ptr == rd_ptr) |-> (PTR_W'(free_space + base) == lim));

endmodule

// File: rtl/rxptr_atomic.sv
module rxptr_atomic
    import rxptr_pkg::*;
#(
    parameter int PTR_W  = rxptr_pkg::PTR_W,
    parameter int BYTE_W = rxptr_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [PTR_W-1:0]  hw_wr_ptr_i,
    input  logic [PTR_W-1:0]  buf_start_i,
    input  logic [PTR_W-1:0]  buf_end_i,
    output logic [PTR_W-1:0]  rd_ptr_o,
    output logic [PTR_W-1:0]  free_o
);
    localparam int HI_W = PTR_W - BYTE_W;

    rxptr_stage_reg #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (byte_sel_e'(wr_sel)),
        .wr_data (wr_data),
        .ptr_q   (rd_ptr_o)
    );

    rxptr_read_mux #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_rdmux (
        .ptr     (rd_ptr_o),
        .rd_sel  (byte_sel_e'(rd_sel)),
        .rd_data (rd_data)
    );

    rxptr_free_calc #(.PTR_W(PTR_W)) u_free (
        .clk        (clk),
        .rst        (rst),
        .rd_ptr     (rd_ptr_o),
        .wr_ptr     (hw_wr_ptr_i),
        .base       (buf_start_i),
        .lim        (buf_end_i),
        .free_space (free_o)
    );

    // R3
    read_match_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data == (rd_sel ? BYTE_W'(rd_ptr_o >> BYTE_W) : rd_ptr_o[BYTE_W-1:0])));

    generate
        if (HI_W < BYTE_W) begin : g_pad_chk
            // R4
            hi_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
                rd_sel |-> (rd_data[BYTE_W-1:HI_W] == '0));
        end
    endgenerate

endmodule

// File: tb/rxptr_atomic_bench.sv
module rxptr_atomic_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        rd_sel = 1'b0;
    logic [7:0]  rd_data;
    logic [12:0] hw_wr_ptr_i = 13'h0;
    logic [12:0] buf_start_i = 13'h0;
    logic [12:0] buf_end_i = 13'h0FFF;
    logic [12:0] rd_ptr_o;
    logic [12:0] free_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rxptr_atomic u_rxptr_atomic (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .hw_wr_ptr_i(hw_wr_ptr_i),
        .buf_start_i(buf_start_i), .buf_end_i(buf_end_i),
        .rd_ptr_o(rd_ptr_o), .free_o(free_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic hi, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = hi; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_both(output logic [7:0] lo, output logic [7:0] hi);
        rd_sel = 1'b1; #1; hi = rd_data;
        rd_sel = 1'b0; #1; lo = rd_data;
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset_state;
        logic [7:0] lo, hi;
        read_both(lo, hi);
        check("R5 ptr after reset", 16'(rd_ptr_o), 16'h0);
        check("R5 lo byte after reset", 16'(lo), 16'h0);
        check("R5 hi byte after reset", 16'(hi), 16'h0);
    endtask

    task automatic t_low_only;
        logic [7:0] lo, hi;
        wr_byte(1'b0, 8'h34);
        read_both(lo, hi);
        check("R1 ptr unchanged by low write", 16'(rd_ptr_o), 16'h0);
        check("R3 staged byte not readable", 16'(lo), 16'h0);
    endtask

    task automatic t_commit;
        logic [7:0] lo, hi;
        wr_byte(1'b1, 8'h12);
        check("R2 commit", 16'(rd_ptr_o), 16'h1234);
        read_both(lo, hi);
        check("R3 read lo", 16'(lo), 16'h34);
        check("R3 read hi", 16'(hi), 16'h12);
    endtask

    task automatic t_hi_pad;
        logic [7:0] lo, hi;
        wr_byte(1'b1, 8'hFF);
        check("R4 R9 upper bits ignored, stage reused", 16'(rd_ptr_o), 16'h1F34);
        read_both(lo, hi);
        check("R4 hi reads padded", 16'(hi), 16'h1F);
    endtask

    task automatic t_last_low_wins;
        wr_byte(1'b0, 8'hAA);
        wr_byte(1'b0, 8'h55);
        check("R1 ptr held over two low writes", 16'(rd_ptr_o), 16'h1F34);
        wr_byte(1'b1, 8'h03);
        check("R9 last low byte used", 16'(rd_ptr_o), 16'h0355);
    endtask

    task automatic t_reset_stage;
        wr_byte(1'b0, 8'h99);
        do_reset();
        check("R5 ptr cleared", 16'(rd_ptr_o), 16'h0);
        wr_byte(1'b1, 8'h07);
        check("R5 staging cleared", 16'(rd_ptr_o), 16'h0700);
    endtask

    task automatic free_case(input string req, input logic [12:0] wp, input logic [12:0] exp);
        @(negedge clk);
        hw_wr_ptr_i = wp; #1;
        check(req, 16'(free_o), 16'(exp));
    endtask

    task automatic t_free;
        wr_byte(1'b0, 8'h00);
        wr_byte(1'b1, 8'h01);
        check("R2 set rd 0x100", 16'(rd_ptr_o), 16'h0100);
        buf_start_i = 13'h0000; buf_end_i = 13'h0FFF;
        free_case("R6 wr ahead", 13'h0300, 13'h0DFF);
        free_case("R6 wr one ahead", 13'h0101, 13'h0FFE);
        free_case("R7 equal", 13'h0100, 13'h0FFF);
        free_case("R8 wr behind", 13'h0050, 13'h00AF);
        free_case("R8 wr one behind", 13'h00FF, 13'h0000);
        buf_start_i = 13'h0200; buf_end_i = 13'h0AFF;
        free_case("R6 offset bounds", 13'h0300, 13'h06FF);
        free_case("R7 offset bounds", 13'h0100, 13'h08FF);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_low_only();
        t_commit();
        t_hi_pad();
        t_last_low_wins();
        t_reset_stage();
        t_free();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule